// File: doc/BRIEF.md
# Bidirectional Handshaked Byte Port

This block connects a CPU-side register interface to one byte-wide peripheral bus that carries data both ways. The CPU writes an outbound byte. The block holds it and lowers an active-low "outbound pending" flag. The peripheral answers with an active-low acknowledge, and for as long as it is held low the block turns on its bus driver with the held byte. At all other times the driver stays off, so the bus is left high impedance. In the other direction, the peripheral drops an active-low strobe to capture the bus into an inbound holding register. This raises "inbound held", and the flag stays up until the CPU finishes reading the byte. The two directions share one interrupt line. Each direction has its own enable, and the CPU sets or clears the enables with single-bit commands.

The CPU side is synchronous to `clk`. Its active-low write and read controls act on their rising edge, and `cpu_sel` picks the data byte (0) or the status/command byte (1). The acknowledge, the strobe and the inbound bus come from the peripheral and are not timed to `clk`. They pass through a `SYNC_STAGES`-deep synchronizer before any state machine sees them.

The outbound state machine has four states:
- `O_IDLE`: nothing pending, driver off.
- `O_FULL`: byte pending, driver off.
- `O_SEND`: acknowledge low, driver on, nothing pending.
- `O_SEND_PEND`: acknowledge low, driver on, and a newer byte was written during the acknowledge.

Its transitions are:
- `O_IDLE` goes to `O_FULL` on a write and to `O_SEND` on an acknowledge.
- `O_FULL` goes to `O_SEND` on an acknowledge.
- `O_SEND` goes back to `O_IDLE` when the acknowledge is released. A write while the acknowledge is held takes it to `O_SEND_PEND`. A write in the same cycle as the release takes it to `O_FULL`.
- `O_SEND_PEND` goes to `O_FULL` when the acknowledge is released.

The inbound state machine has three states:
- `I_EMPTY`: no byte held.
- `I_LOAD`: strobe low, bus being captured.
- `I_FULL`: byte held.

Its transitions are:
- `I_EMPTY` goes to `I_LOAD` when the strobe falls.
- `I_LOAD` goes to `I_FULL` when the strobe rises.
- `I_FULL` goes to `I_EMPTY` when a data read completes, and back to `I_LOAD` if a new strobe arrives first.

Top module: `bidir_strobe_port`

## Requirements
- R1: A completed data write (`cpu_wr_n` rising with `cpu_sel`=0) stores `cpu_wdata` and drives `obf_n` low from the next clock edge on.
- R2: While the synchronized acknowledge is low, `pbus_oe` is 1 and `pbus_out` carries the stored outbound byte. An acknowledge that finds a byte pending returns `obf_n` high. While the acknowledge is high, `pbus_oe` is 0.
- R3: A low strobe captures `pbus_in` and raises `ibf`. `ibf` stays 1 until a data read (`cpu_rd_n` rising with `cpu_sel`=0) completes while the strobe is high.
- R4: A data read returns the last byte captured by the strobe, and reading it again returns the same byte.
- R5: A status read (`cpu_sel`=1) returns the following bits: bit 7 `obf_n`, bit 6 outbound enable, bit 5 `ibf`, bit 4 inbound enable, bit 3 `intr`. Bits 2..0 read as 0.
- R6: A command write (`cpu_sel`=1) with bit 7 = 0 uses bits 3..1 as a bit index and bit 0 as the new value. Index 6 sets the outbound enable and index 4 sets the inbound enable. Every other index, and every word with bit 7 = 1, changes nothing.
- R7: `intr` is (outbound enable AND outbound request) OR (inbound enable AND inbound request). The outbound request is 1 after reset. It is cleared while a data write is low and set again when an acknowledge ends with no newer byte pending. The inbound request is set when the strobe returns high and cleared while a data read is low.
- R8: A data write made while the acknowledge is held low is driven onto the bus at once and lowers `obf_n`. When the acknowledge is released, the driver turns off and `obf_n` stays low until the next acknowledge.
- R9: Reset, or a later assertion of `rst_n` low, gives the following state: `obf_n`=1, `ibf`=0, both enables 0, `intr`=0, `pbus_oe`=0, both stored bytes 0.
- R10: A new strobe arriving while a byte is already held replaces it. `ibf` stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | 0: data byte, 1: status read / command write |
| cpu_wr_n | input | 1 | CPU write, active low, acts on rising edge |
| cpu_rd_n | input | 1 | CPU read, active low, completes on rising edge |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data |
| pbus_in | input | DATA_W | Peripheral bus as seen at the pins |
| pbus_out | output | DATA_W | Outbound byte for the bus driver |
| pbus_oe | output | 1 | Bus driver enable, 0 leaves the bus high impedance |
| obf_n | output | 1 | Outbound byte pending, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| ibf | output | 1 | Inbound byte held |
| intr | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `DATA_W`=8 and `SYNC_STAGES`=2. This makes the byte layouts of the status and command words exact. Each peripheral action then takes three clock edges to reach the state machines, so the handshakes are held long enough for that latency to be covered. With these values the bench can reach:
- a write landing inside an acknowledge window (`O_SEND_PEND`);
- a strobe overwriting a held byte;
- command words that must be ignored;
- the interrupt sourced from each direction alone.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    // Outbound (CPU to peripheral) handshake states
    typedef enum logic [1:0] {
        O_IDLE      = 2'd0,
        O_FULL      = 2'd1,
        O_SEND      = 2'd2,
        O_SEND_PEND = 2'd3
    } out_state_t;

    // Inbound (peripheral to CPU) handshake states
    typedef enum logic [1:0] {
        I_EMPTY = 2'd0,
        I_LOAD  = 2'd1,
        I_FULL  = 2'd2
    } in_state_t;

    // Command word layout: flag bit must be 0, index in [3:1], value in [0]
    localparam int unsigned CMD_FLAG_BIT = 7;
    localparam int unsigned CMD_IDX_LSB  = 1;
    localparam int unsigned CMD_IDX_W    = 3;
    localparam int unsigned OUT_EN_IDX   = 6;
    localparam int unsigned IN_EN_IDX    = 4;

    // Status byte width
    localparam int unsigned STAT_W       = 8;

endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(STAGES); i++) begin
                        stg[i] <= RST_VAL;
                    end
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bsp_out_fsm.sv
module bsp_out_fsm
    import bsp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rise,   // data write completed this cycle
    input  logic              wr_low,    // data write in progress
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_low,   // synchronized acknowledge
    output logic              obf_n,
    output logic              drive_oe,
    output logic [DATA_W-1:0] drive_data,
    output logic              out_req
);

    out_state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= O_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            O_IDLE: begin
                if (ack_low) begin
                    state_nx = wr_rise ? O_SEND_PEND : O_SEND;
                end else if (wr_rise) begin
                    state_nx = O_FULL;
                end
            end
            O_FULL: begin
                if (ack_low) begin
                    state_nx = wr_rise ? O_SEND_PEND : O_SEND;
                end
            end
            O_SEND: begin
                if (!ack_low) begin
                    state_nx = wr_rise ? O_FULL : O_IDLE;
                end else if (wr_rise) begin
                    state_nx = O_SEND_PEND;
                end
            end
            O_SEND_PEND: begin
                if (!ack_low) begin
                    state_nx = O_FULL;
                end
            end
            default: state_nx = O_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        obf_n    = 1'b1;
        drive_oe = 1'b0;
        unique case (state)
            O_IDLE:      begin obf_n = 1'b1; drive_oe = 1'b0; end
            O_FULL:      begin obf_n = 1'b0; drive_oe = 1'b0; end
            O_SEND:      begin obf_n = 1'b1; drive_oe = 1'b1; end
            O_SEND_PEND: begin obf_n = 1'b0; drive_oe = 1'b1; end
            default:     begin obf_n = 1'b1; drive_oe = 1'b0; end
        endcase
    end

    // Outbound holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_data <= '0;
        end else if (wr_rise) begin
            drive_data <= wdata;
        end
    end

    // Outbound interrupt request: armed at reset and after a completed transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_req <= 1'b1;
        end else if (wr_low) begin
            out_req <= 1'b0;
        end else if (state == O_SEND && !ack_low && !wr_rise) begin
            out_req <= 1'b1;
        end
    end

endmodule

// File: rtl/bsp_in_fsm.sv
module bsp_in_fsm
    import bsp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_low,   // synchronized strobe
    input  logic [DATA_W-1:0] bus,       // synchronized bus
    input  logic              rd_rise,   // data read completed this cycle
    input  logic              rd_low,    // data read in progress
    output logic              ibf,
    output logic [DATA_W-1:0] in_data,
    output logic              in_req
);

    in_state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= I_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            I_EMPTY: if (stb_low) state_nx = I_LOAD;
            I_LOAD:  if (!stb_low) state_nx = I_FULL;
            I_FULL: begin
                if (stb_low) begin
                    state_nx = I_LOAD;
                end else if (rd_rise) begin
                    state_nx = I_EMPTY;
                end
            end
            default: state_nx = I_EMPTY;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        unique case (state)
            I_EMPTY: ibf = 1'b0;
            I_LOAD:  ibf = 1'b1;
            I_FULL:  ibf = 1'b1;
            default: ibf = 1'b0;
        endcase
    end

    // Inbound holding register follows the bus while the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_data <= '0;
        end else if (stb_low) begin
            in_data <= bus;
        end
    end

    // Inbound interrupt request: set when the strobe completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_req <= 1'b0;
        end else if (rd_low) begin
            in_req <= 1'b0;
        end else if (state == I_LOAD && !stb_low) begin
            in_req <= 1'b1;
        end
    end

endmodule

// File: rtl/bsp_ctl.sv
module bsp_ctl
    import bsp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rise,  // command write completed this cycle
    input  logic [DATA_W-1:0] wdata,
    output logic              out_en,
    output logic              in_en
);

    logic [CMD_IDX_W-1:0] idx;
    logic                 cmd_ok;

    assign idx    = wdata[CMD_IDX_LSB +: CMD_IDX_W];
    assign cmd_ok = cmd_rise && !wdata[CMD_FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en <= 1'b0;
            in_en  <= 1'b0;
        end else if (cmd_ok) begin
            if (idx == CMD_IDX_W'(OUT_EN_IDX)) out_en <= wdata[0];
            if (idx == CMD_IDX_W'(IN_EN_IDX))  in_en  <= wdata[0];
        end
    end

endmodule

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port
    import bsp_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr_n,
    input  logic              cpu_rd_n,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [DATA_W-1:0] pbus_in,
    output logic [DATA_W-1:0] pbus_out,
    output logic              pbus_oe,
    output logic              obf_n,
    input  logic              ack_n,
    input  logic              stb_n,
    output logic              ibf,
    output logic              intr
);

    localparam int unsigned SYNC_W = DATA_W + 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {DATA_W{1'b0}}};

    // CPU edge detection
    logic wr_q, rd_q;
    logic wr_rise_d, wr_low_d, cmd_rise, rd_rise_d, rd_low_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= cpu_wr_n;
            rd_q <= cpu_rd_n;
        end
    end

    assign wr_rise_d = cpu_wr_n && !wr_q && !cpu_sel;
    assign cmd_rise  = cpu_wr_n && !wr_q &&  cpu_sel;
    assign wr_low_d  = !cpu_wr_n && !cpu_sel;
    assign rd_rise_d = cpu_rd_n && !rd_q && !cpu_sel;
    assign rd_low_d  = !cpu_rd_n && !cpu_sel;

    // Peripheral-side synchronizer
    logic [SYNC_W-1:0] per_s;
    logic              ack_low, stb_low;
    logic [DATA_W-1:0] bus_s;

    bsp_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({stb_n, ack_n, pbus_in}),
        .q     (per_s)
    );

    assign stb_low = !per_s[DATA_W+1];
    assign ack_low = !per_s[DATA_W];
    assign bus_s   = per_s[DATA_W-1:0];

    // Enables
    logic out_en, in_en;

    bsp_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_rise (cmd_rise),
        .wdata    (cpu_wdata),
        .out_en   (out_en),
        .in_en    (in_en)
    );

    // Outbound direction
    logic out_req;

    bsp_out_fsm #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_rise    (wr_rise_d),
        .wr_low     (wr_low_d),
        .wdata      (cpu_wdata),
        .ack_low    (ack_low),
        .obf_n      (obf_n),
        .drive_oe   (pbus_oe),
        .drive_data (pbus_out),
        .out_req    (out_req)
    );

    // Inbound direction
    logic              in_req;
    logic [DATA_W-1:0] in_data;

    bsp_in_fsm #(.DATA_W(DATA_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_low (stb_low),
        .bus     (bus_s),
        .rd_rise (rd_rise_d),
        .rd_low  (rd_low_d),
        .ibf     (ibf),
        .in_data (in_data),
        .in_req  (in_req)
    );

    // Shared interrupt
    assign intr = (out_en && out_req) || (in_en && in_req);

    // CPU read mux
    logic [STAT_W-1:0] status;
    assign status = {obf_n, out_en, ibf, in_en, intr, 3'b000};

    always_comb begin
        if (cpu_sel) begin
            cpu_rdata = DATA_W'(status);
        end else begin
            cpu_rdata = in_data;
        end
    end

endmodule

// File: rtl/bsp_port_chk.sv
module bsp_port_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_rd_n,
    input logic              obf_n,
    input logic              ibf,
    input logic              intr,
    input logic              pbus_oe,
    input logic [DATA_W-1:0] pbus_out,
    input logic              ack_low,
    input logic              stb_low,
    input logic              out_en,
    input logic              in_en,
    input logic              wr_rise
);

    // R1: a completed data write leaves a byte pending
    assert_obf_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> !obf_n);

    // R2: acknowledge start turns the driver on and clears pending
    assert_drive_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_low) |=> !pbus_oe);

    assert_drive_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_low) |=> pbus_oe);

    assert_obf_clears_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_low) && !wr_rise) |=> obf_n);

    assert_bus_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_oe && $past(pbus_oe) && !$past(wr_rise)) |-> $stable(pbus_out));

    // R3: strobe raises ibf, completed read while idle lowers it
    assert_ibf_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_low) |=> ibf);

    assert_ibf_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_rd_n) && !cpu_sel && ibf && !stb_low && !$past(stb_low))
        |=> !ibf);

    // R7: no interrupt with both enables off
    assert_intr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !in_en) |-> !intr);

endmodule

bind bidir_strobe_port bsp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_sel  (cpu_sel),
    .cpu_rd_n (cpu_rd_n),
    .obf_n    (obf_n),
    .ibf      (ibf),
    .intr     (intr),
    .pbus_oe  (pbus_oe),
    .pbus_out (pbus_out),
    .ack_low  (ack_low),
    .stb_low  (stb_low),
    .out_en   (out_en),
    .in_en    (in_en),
    .wr_rise  (wr_rise_d)
);

// File: tb/bidir_strobe_port_test.sv
module bidir_strobe_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int HOLD       = SYNC + 3;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_CMD  = 3'd1;
    localparam logic [2:0] OP_ACK  = 3'd2;
    localparam logic [2:0] OP_STB  = 3'd3;
    localparam logic [2:0] OP_RDD  = 3'd4;
    localparam logic [2:0] OP_RDS  = 3'd5;

    localparam int NVEC = 29;
    // {op, data, expected}
    localparam logic [18:0] VEC [NVEC] = '{
        {OP_RDS, 8'h00, 8'h80},  // R9 reset status
        {OP_CMD, 8'h0D, 8'h00},  // R6 set outbound enable
        {OP_RDS, 8'h00, 8'hC8},  // R5 R7 outbound request visible
        {OP_CMD, 8'h09, 8'h00},  // R6 set inbound enable
        {OP_RDS, 8'h00, 8'hD8},
        {OP_WR,  8'hA5, 8'h00},  // R1
        {OP_RDS, 8'h00, 8'h50},  // R1 R7 pending, request cleared
        {OP_ACK, 8'h00, 8'hA5},  // R2
        {OP_RDS, 8'h00, 8'hD8},  // R7 request back
        {OP_STB, 8'h3C, 8'h00},  // R3
        {OP_RDS, 8'h00, 8'hF8},
        {OP_RDD, 8'h00, 8'h3C},  // R4
        {OP_RDD, 8'h00, 8'h3C},  // R4 re-read
        {OP_RDS, 8'h00, 8'hD8},  // R3 ibf cleared
        {OP_CMD, 8'h0C, 8'h00},  // R6 clear outbound enable
        {OP_RDS, 8'h00, 8'h90},
        {OP_CMD, 8'h0B, 8'h00},  // R6 index 5 ignored
        {OP_CMD, 8'h8D, 8'h00},  // R6 flag bit set, ignored
        {OP_RDS, 8'h00, 8'h90},
        {OP_STB, 8'h11, 8'h00},  // R10
        {OP_STB, 8'h22, 8'h00},  // R10 overwrite
        {OP_RDS, 8'h00, 8'hB8},
        {OP_RDD, 8'h00, 8'h22},  // R10 newest byte
        {OP_RDS, 8'h00, 8'h90},
        {OP_WR,  8'h5A, 8'h00},
        {OP_WR,  8'h6B, 8'h00},  // R1 second write replaces
        {OP_RDS, 8'h00, 8'h10},
        {OP_ACK, 8'h00, 8'h6B},  // R2
        {OP_RDS, 8'h00, 8'h90}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0;
    logic       cpu_wr_n = 1'b1;
    logic       cpu_rd_n = 1'b1;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] pbus_in = '0;
    logic [7:0] pbus_out;
    logic       pbus_oe;
    logic       obf_n;
    logic       ack_n = 1'b1;
    logic       stb_n = 1'b1;
    logic       ibf;
    logic       intr;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_strobe_port #(.DATA_W(8), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr_n(cpu_wr_n),
        .cpu_rd_n(cpu_rd_n), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pbus_in(pbus_in), .pbus_out(pbus_out), .pbus_oe(pbus_oe),
        .obf_n(obf_n), .ack_n(ack_n), .stb_n(stb_n), .ibf(ibf), .intr(intr)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = d; cpu_wr_n = 1'b0;
        @(negedge clk);
        cpu_wr_n = 1'b1;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic cpu_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_rd_n = 1'b0;
        @(negedge clk);
        d = cpu_rdata;
        cpu_rd_n = 1'b1;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] d);
        @(negedge clk);
        pbus_in = d; stb_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        stb_n = 1'b1;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R9 reset state at the ports
        check("R9 obf_n", {7'd0, obf_n}, 8'h01);
        check("R9 ibf", {7'd0, ibf}, 8'h00);
        check("R9 oe", {7'd0, pbus_oe}, 8'h00);
        check("R9 intr", {7'd0, intr}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] op;
            logic [7:0] d, e;
            op = VEC[i][18:16]; d = VEC[i][15:8]; e = VEC[i][7:0];
            case (op)
                OP_WR:  cpu_write(1'b0, d);
                OP_CMD: cpu_write(1'b1, d);
                OP_STB: strobe(d);
                OP_RDD: begin cpu_read(1'b0, rd); check("R4 data read", rd, e); end
                OP_RDS: begin cpu_read(1'b1, rd); check("R5 R6 R7 status", rd, e); end
                OP_ACK: begin
                    @(negedge clk); ack_n = 1'b0;
                    repeat (HOLD) @(negedge clk);
                    check("R2 bus data", pbus_out, e);
                    check("R2 oe during ack", {7'd0, pbus_oe}, 8'h01);
                    check("R2 obf_n during ack", {7'd0, obf_n}, 8'h01);
                    ack_n = 1'b1;
                    repeat (HOLD) @(negedge clk);
                    check("R2 oe after ack", {7'd0, pbus_oe}, 8'h00);
                end
                default: ;
            endcase
        end

        // R8: write during acknowledge
        cpu_write(1'b1, 8'h0D);
        @(negedge clk); ack_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        cpu_write(1'b0, 8'h77);
        check("R8 new byte driven", pbus_out, 8'h77);
        check("R8 oe held", {7'd0, pbus_oe}, 8'h01);
        check("R8 obf_n low", {7'd0, obf_n}, 8'h00);
        ack_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        check("R8 oe off", {7'd0, pbus_oe}, 8'h00);
        check("R8 obf_n still low", {7'd0, obf_n}, 8'h00);
        check("R7 no outbound intr while pending", {7'd0, intr}, 8'h00);
        @(negedge clk); ack_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        check("R8 second ack data", pbus_out, 8'h77);
        check("R2 obf_n high on ack", {7'd0, obf_n}, 8'h01);
        ack_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        check("R7 outbound intr", {7'd0, intr}, 8'h01);

        // R7: inbound-only interrupt
        cpu_write(1'b1, 8'h0C);
        check("R7 outbound gated", {7'd0, intr}, 8'h00);
        strobe(8'h44);
        check("R7 inbound intr", {7'd0, intr}, 8'h01);
        cpu_read(1'b0, rd);
        check("R3 read data", rd, 8'h44);
        check("R7 inbound intr cleared", {7'd0, intr}, 8'h00);
        check("R3 ibf cleared", {7'd0, ibf}, 8'h00);

        // R9: reset in mid-run with a byte pending
        cpu_write(1'b0, 8'h99);
        strobe(8'h55);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 obf_n after reset", {7'd0, obf_n}, 8'h01);
        check("R9 ibf after reset", {7'd0, ibf}, 8'h00);
        cpu_read(1'b1, rd);
        check("R9 status after reset", rd, 8'h80);
        cpu_read(1'b0, rd);
        check("R9 inbound byte cleared", rd, 8'h00);
        @(negedge clk); ack_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        check("R9 outbound byte cleared", pbus_out, 8'h00);
        ack_n = 1'b1;
        repeat (HOLD) @(negedge clk);

        finish_run();
    end

endmodule